// File: doc/BRIEF.md
# Serial Memory Slave Protocol Engine

This block is the bus-facing half of a 2048-byte serial memory. It watches the four slave pins: select (active low), serial clock, serial data in and a pause pin (active low). It decodes a one-byte command, collects a two-byte address where the command needs one, and either returns data on the serial output or raises single-cycle strobes towards the neighbouring blocks. Those neighbours are the storage array, the status register with its protection policy, and the page buffer. The neighbours decide whether a strobe is honoured. This engine only checks that the bus framing was legal.

The pins are not sampled on their own clock. They pass through a synchroniser into a faster system clock, and serial clock edges are found there. The serial output is a data bit plus an enable, not a tristate pad, so the pad ring owns the high-impedance state. Reads of the array stream forward from the loaded address and wrap at the top. A status read repeats the status byte for as long as the master keeps clocking.

Top module: `spi_mem_front`

## Requirements
- R1: After reset the engine ignores the bus until select has been seen high and then low. While it is not selected, or after the first system clock in which the synchronised select is high, the output enable is 0.
- R2: Command byte 0x06 followed by select rising exactly on the byte boundary gives one `wren_stb`. Command byte 0x04 handled the same way gives one `wrdi_stb`.
- R3: Input bits are latched on rising serial clock edges and output bits change only after falling edges. Clock idle level low (mode 0) and idle level high (mode 3) both work.
- R4: Command 0x05 shifts out `stat_in` MSB first and repeats it for each further byte while select stays low. The output enable is 1 while the byte is shifted.
- R5: Command 0x03 takes a high address byte and then a low address byte, MSB first. Only the low 11 address bits are used. The engine returns the byte at that address, then the next addresses in turn, wrapping from 0x7FF to 0x000.
- R6: Command 0x03 received while `wip_in` is 1 is refused. The output enable stays 0 until deselect.
- R7: Command 0x02 plus address gives one `wbyte_stb` per completed data byte, with the running address and the byte. Select rising on a byte boundary after at least one data byte gives one `wcommit_stb`.
- R8: A write, status write, write-enable or write-disable command that ends with extra bits past its last byte produces no commit or latch strobe.
- R9: Command 0x01 followed by exactly one data byte gives one `wrsr_stb`, with that byte on `wrsr_data`.
- R10: An unknown command byte parks the engine. Later bytes in the same select period give no strobe and no output.
- R11: Pause takes effect only while the serial clock is low. While paused the output enable is 0, clock and data-in are ignored, and the bit position is kept.
- R12: Deselecting while paused resets the protocol state. A write command that was complete on a byte boundary still gives `wcommit_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Slave select pin, active low |
| sck | input | 1 | Serial clock pin |
| mosi | input | 1 | Serial data in pin |
| hold_n | input | 1 | Pause pin, active low |
| miso | output | 1 | Serial data out value |
| miso_oe | output | 1 | Drive enable for `miso` |
| mem_addr | output | 11 | Array read address |
| mem_rdata | input | 8 | Array byte at `mem_addr`, combinational |
| stat_in | input | 8 | Status byte to return on status read |
| wip_in | input | 1 | Internal write cycle busy |
| wren_stb | output | 1 | Set write-enable latch |
| wrdi_stb | output | 1 | Clear write-enable latch |
| wrsr_stb | output | 1 | Status write request |
| wrsr_data | output | 8 | Status write value |
| wbyte_stb | output | 1 | One data byte for the page buffer |
| wbyte_addr | output | 11 | Address of that byte |
| wbyte_data | output | 8 | Value of that byte |
| wcommit_stb | output | 1 | Launch the write cycle |

## Verification
The bench probes how select, clock and pause interact at byte edges. It ends writes one, three and zero bits past a boundary, and it deselects in the middle of a pause. A design with a loose bit count would commit a torn write, and one that forgot the pending write on a paused deselect would drop it silently. The bench streams a read across the 0x7FF to 0x000 wrap and clocks through a pause in the middle of a read byte. A design with a wrong wrap would return the wrong bytes after the top address. A design that let clock edges through while paused would return the rest of the stream shifted by the stray bits. The bench also holds select low through reset and sends a command before any falling edge; a design that missed this would latch the write enable.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
   localparam int BYTE_W = 8;

   localparam logic [BYTE_W-1:0] CMD_LATCH_ON  = 8'h06;
   localparam logic [BYTE_W-1:0] CMD_LATCH_OFF = 8'h04;
   localparam logic [BYTE_W-1:0] CMD_STAT_RD   = 8'h05;
   localparam logic [BYTE_W-1:0] CMD_STAT_WR   = 8'h01;
   localparam logic [BYTE_W-1:0] CMD_ARR_RD    = 8'h03;
   localparam logic [BYTE_W-1:0] CMD_ARR_WR    = 8'h02;

   typedef enum logic [3:0] {
      PH_IDLE,
      PH_CMD,
      PH_ADDR,
      PH_RDARR,
      PH_RDSTAT,
      PH_WRDATA,
      PH_SRBYTE,
      PH_SRFULL,
      PH_LATCH_ON,
      PH_LATCH_OFF,
      PH_PARK
   } phase_e;
endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("spi_mem_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] pipe [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[0] <= '0;
               else        pipe[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[s] <= '0;
               else        pipe[s] <= pipe[s-1];
            end
         end
      end
   endgenerate

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_mem_rx.sv
module spi_mem_rx #(
   parameter int BW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          sample,
   input  logic          din,
   output logic [BW-1:0] byte_q,
   output logic          byte_done,
   output logic          at_bound
);
   localparam int CW = $clog2(BW);
   localparam logic [CW-1:0] LAST = CW'(BW - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_q    <= '0;
         cnt       <= '0;
         byte_done <= 1'b0;
      end else if (clr) begin
         cnt       <= '0;
         byte_done <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         if (sample) begin
            byte_q    <= {byte_q[BW-2:0], din};
            cnt       <= (cnt == LAST) ? '0 : cnt + 1'b1;
            byte_done <= (cnt == LAST);
         end
      end
   end

   assign at_bound = (cnt == '0);
endmodule

// File: rtl/spi_mem_tx.sv
module spi_mem_tx #(
   parameter int BW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          load,
   input  logic [BW-1:0] load_val,
   input  logic          shift,
   output logic          bit_q,
   output logic          byte_end
);
   localparam int CW = $clog2(BW);
   localparam logic [CW-1:0] TOP = CW'(BW - 1);

   logic [BW-1:0] hold_byte;
   logic [CW-1:0] idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_byte <= '0;
         idx       <= TOP;
         bit_q     <= 1'b0;
      end else if (clr) begin
         idx       <= TOP;
      end else begin
         if (load) hold_byte <= load_val;
         if (shift) begin
            bit_q <= hold_byte[idx];
            idx   <= (idx == '0) ? TOP : idx - 1'b1;
         end
      end
   end

   assign byte_end = shift && (idx == '0);
endmodule

// File: rtl/spi_mem_front.sv
module spi_mem_front
   import spi_mem_pkg::*;
#(
   parameter int ADDR_BITS   = 11,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cs_n,
   input  logic                 sck,
   input  logic                 mosi,
   input  logic                 hold_n,
   output logic                 miso,
   output logic                 miso_oe,
   output logic [ADDR_BITS-1:0] mem_addr,
   input  logic [BYTE_W-1:0]    mem_rdata,
   input  logic [BYTE_W-1:0]    stat_in,
   input  logic                 wip_in,
   output logic                 wren_stb,
   output logic                 wrdi_stb,
   output logic                 wrsr_stb,
   output logic [BYTE_W-1:0]    wrsr_data,
   output logic                 wbyte_stb,
   output logic [ADDR_BITS-1:0] wbyte_addr,
   output logic [BYTE_W-1:0]    wbyte_data,
   output logic                 wcommit_stb
);
   localparam int HI_W = ADDR_BITS - BYTE_W;

   generate
      if (ADDR_BITS <= BYTE_W || ADDR_BITS > 2 * BYTE_W) begin : g_bad_addr
         $error("spi_mem_front: ADDR_BITS must lie in 9..16");
      end
   endgenerate

   // pin synchronisation: bit 0 select, 1 clock, 2 data, 3 pause
   logic [3:0] pins_s;
   spi_mem_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({hold_n, mosi, sck, cs_n}),
      .q    (pins_s)
   );

   logic cs_s, sck_s, mosi_s, hold_s;
   assign cs_s   = pins_s[0];
   assign sck_s  = pins_s[1];
   assign mosi_s = pins_s[2];
   assign hold_s = pins_s[3];

   logic cs_p, sck_p;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_p  <= 1'b0;
         sck_p <= 1'b0;
      end else begin
         cs_p  <= cs_s;
         sck_p <= sck_s;
      end
   end

   // select and pause tracking
   logic cs_fall, cs_rise, sel, held;
   assign cs_fall = cs_p & ~cs_s;
   assign cs_rise = ~cs_p & cs_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sel <= 1'b0;
      else if (cs_rise) sel <= 1'b0;
      else if (cs_fall) sel <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      held <= 1'b0;
      else if (!sel)   held <= 1'b0;
      else if (!sck_s) held <= ~hold_s;
   end

   phase_e phase;
   logic   out_phase;
   assign out_phase = (phase == PH_RDARR) || (phase == PH_RDSTAT);

   logic rx_sample, tx_shift;
   assign rx_sample = sel & ~held & ~sck_p & sck_s;
   assign tx_shift  = sel & ~held & sck_p & ~sck_s & out_phase;

   // shifters
   logic [BYTE_W-1:0] rx_byte;
   logic              rx_done, rx_bound;
   spi_mem_rx #(.BW(BYTE_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (~sel),
      .sample   (rx_sample),
      .din      (mosi_s),
      .byte_q   (rx_byte),
      .byte_done(rx_done),
      .at_bound (rx_bound)
   );

   logic reload, tx_end;
   spi_mem_tx #(.BW(BYTE_W)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (~sel),
      .load    (reload),
      .load_val((phase == PH_RDSTAT) ? stat_in : mem_rdata),
      .shift   (tx_shift),
      .bit_q   (miso),
      .byte_end(tx_end)
   );

   // command sequencer
   logic [ADDR_BITS-1:0] addr;
   logic [HI_W-1:0]      addr_hi;
   logic                 addr_second, is_read, wr_any, out_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase       <= PH_IDLE;
         addr        <= '0;
         addr_hi     <= '0;
         addr_second <= 1'b0;
         is_read     <= 1'b0;
         wr_any      <= 1'b0;
         out_on      <= 1'b0;
         reload      <= 1'b0;
         wren_stb    <= 1'b0;
         wrdi_stb    <= 1'b0;
         wrsr_stb    <= 1'b0;
         wrsr_data   <= '0;
         wbyte_stb   <= 1'b0;
         wbyte_addr  <= '0;
         wbyte_data  <= '0;
         wcommit_stb <= 1'b0;
      end else begin
         wren_stb    <= 1'b0;
         wrdi_stb    <= 1'b0;
         wrsr_stb    <= 1'b0;
         wbyte_stb   <= 1'b0;
         wcommit_stb <= 1'b0;
         reload      <= 1'b0;
         if (cs_rise && sel) begin
            unique case (phase)
               PH_LATCH_ON:  wren_stb    <= 1'b1;
               PH_LATCH_OFF: wrdi_stb    <= 1'b1;
               PH_SRFULL:    wrsr_stb    <= 1'b1;
               PH_WRDATA:    wcommit_stb <= rx_bound & wr_any;
               default: ;
            endcase
            phase  <= PH_IDLE;
            out_on <= 1'b0;
            wr_any <= 1'b0;
         end else if (cs_fall) begin
            phase       <= PH_CMD;
            addr_second <= 1'b0;
            out_on      <= 1'b0;
            wr_any      <= 1'b0;
         end else if (sel) begin
            if (tx_shift) out_on <= 1'b1;
            if (tx_end) begin
               reload <= 1'b1;
               if (phase == PH_RDARR) addr <= addr + 1'b1;
            end
            if (rx_sample && (phase inside {PH_LATCH_ON, PH_LATCH_OFF, PH_SRFULL})) begin
               phase <= PH_PARK;
            end else if (rx_done) begin
               unique case (phase)
                  PH_CMD: begin
                     unique case (rx_byte)
                        CMD_LATCH_ON:  phase <= PH_LATCH_ON;
                        CMD_LATCH_OFF: phase <= PH_LATCH_OFF;
                        CMD_STAT_RD: begin
                           phase  <= PH_RDSTAT;
                           reload <= 1'b1;
                        end
                        CMD_STAT_WR:   phase <= PH_SRBYTE;
                        CMD_ARR_RD: begin
                           phase   <= wip_in ? PH_PARK : PH_ADDR;
                           is_read <= 1'b1;
                        end
                        CMD_ARR_WR: begin
                           phase   <= PH_ADDR;
                           is_read <= 1'b0;
                        end
                        default:       phase <= PH_PARK;
                     endcase
                  end
                  PH_ADDR: begin
                     if (!addr_second) begin
                        addr_hi     <= rx_byte[HI_W-1:0];
                        addr_second <= 1'b1;
                     end else begin
                        addr   <= {addr_hi, rx_byte};
                        phase  <= is_read ? PH_RDARR : PH_WRDATA;
                        reload <= is_read;
                     end
                  end
                  PH_WRDATA: begin
                     wbyte_stb  <= 1'b1;
                     wbyte_addr <= addr;
                     wbyte_data <= rx_byte;
                     addr       <= addr + 1'b1;
                     wr_any     <= 1'b1;
                  end
                  PH_SRBYTE: begin
                     wrsr_data <= rx_byte;
                     phase     <= PH_SRFULL;
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   assign mem_addr = addr;
   assign miso_oe  = sel & ~held & out_on;
endmodule

// File: rtl/spi_mem_front_chk.sv
module spi_mem_front_chk (
   input logic clk,
   input logic rst_n,
   input logic cs_sync,
   input logic held,
   input logic shift,
   input logic miso,
   input logic miso_oe,
   input logic wren_stb,
   input logic wrdi_stb,
   input logic wrsr_stb,
   input logic wbyte_stb,
   input logic wcommit_stb
);
   a_r1_quiet_after_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      miso_oe |-> !$past(cs_sync));

   a_r3_out_moves_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (miso_oe && $past(miso_oe) && (miso != $past(miso))) |-> $past(shift));

   a_r11_paused_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      held |-> !miso_oe);

   a_r2_one_strobe_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wren_stb, wrdi_stb, wrsr_stb, wbyte_stb, wcommit_stb}));

   a_r7_commit_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      wcommit_stb |=> !wcommit_stb);

   a_r9_status_write_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      wrsr_stb |=> !wrsr_stb);
endmodule

bind spi_mem_front spi_mem_front_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_sync    (cs_s),
   .held       (held),
   .shift      (tx_shift),
   .miso       (miso),
   .miso_oe    (miso_oe),
   .wren_stb   (wren_stb),
   .wrdi_stb   (wrdi_stb),
   .wrsr_stb   (wrsr_stb),
   .wbyte_stb  (wbyte_stb),
   .wcommit_stb(wcommit_stb)
);

// File: tb/tb_spi_mem_front.sv
module tb_spi_mem_front;
   localparam int HP = 8;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n, cs_n, sck, mosi, hold_n, wip_in;
   logic        miso, miso_oe;
   logic [10:0] mem_addr, wbyte_addr;
   logic [7:0]  mem_rdata, stat_in, wrsr_data, wbyte_data;
   logic        wren_stb, wrdi_stb, wrsr_stb, wbyte_stb, wcommit_stb;

   logic [7:0] mem [0:2047];
   assign mem_rdata = mem[mem_addr];

   spi_mem_front dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .hold_n(hold_n),
      .miso(miso), .miso_oe(miso_oe), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .stat_in(stat_in), .wip_in(wip_in), .wren_stb(wren_stb), .wrdi_stb(wrdi_stb),
      .wrsr_stb(wrsr_stb), .wrsr_data(wrsr_data), .wbyte_stb(wbyte_stb),
      .wbyte_addr(wbyte_addr), .wbyte_data(wbyte_data), .wcommit_stb(wcommit_stb)
   );

   int total = 0;
   int bad   = 0;
   int n_en = 0, n_di = 0, n_sr = 0, n_cm = 0;
   logic [7:0]  last_sr;
   logic [10:0] wq_a [$];
   logic [7:0]  wq_d [$];
   logic        saw_oe;
   logic        mode3;

   // strobe monitor, the reference side of the comparison
   always @(posedge clk) begin
      if (wren_stb)    n_en++;
      if (wrdi_stb)    n_di++;
      if (wrsr_stb)    begin n_sr++; last_sr = wrsr_data; end
      if (wcommit_stb) n_cm++;
      if (wbyte_stb)   begin wq_a.push_back(wbyte_addr); wq_d.push_back(wbyte_data); end
      if (miso_oe)     saw_oe = 1'b1;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_x(input logic b, output logic r);
      sck  = 1'b0;
      mosi = b;
      wait_clk(HP);
      r    = miso;
      sck  = 1'b1;
      wait_clk(HP);
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         logic r;
         bit_x(tx[i], r);
         rx[i] = r;
      end
   endtask

   task automatic send(input logic [7:0] tx);
      logic [7:0] dummy;
      xfer(tx, dummy);
   endtask

   task automatic sel_on(input logic m3);
      mode3 = m3;
      sck   = m3;
      wait_clk(HP);
      cs_n  = 1'b0;
      saw_oe = 1'b0;
      wait_clk(HP);
   endtask

   task automatic sel_off();
      if (!mode3) begin sck = 1'b0; wait_clk(HP); end
      cs_n = 1'b1;
      wait_clk(3 * HP);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] rx;
      logic       r;
      for (int i = 0; i < 2048; i++) mem[i] = 8'((i * 7 + 3) ^ (i >> 8));
      rst_n = 1'b0; cs_n = 1'b0; sck = 1'b0; mosi = 1'b0; hold_n = 1'b1;
      wip_in = 1'b0; stat_in = 8'hA6; mode3 = 1'b0; saw_oe = 1'b0;
      wait_clk(6);
      rst_n = 1'b1;
      wait_clk(4);
      check("R1 reset enable", miso_oe, 0);
      // R1: select low from reset, no falling edge seen yet
      send(8'h06);
      sel_off();
      check("R1 no response before first fall", n_en, 0);

      // R2: latch on / off
      sel_on(0); send(8'h06); sel_off();
      check("R2 latch on strobe", n_en, 1);
      sel_on(1); send(8'h04); sel_off();
      check("R2 latch off strobe", n_di, 1);

      // R4 and R3: status read, mode 0 then mode 3, repeated bytes
      sel_on(0); send(8'h05); xfer(8'h00, rx);
      check("R4 status byte mode0", rx, 8'hA6);
      check("R4 output enabled", saw_oe, 1);
      xfer(8'h00, rx); sel_off();
      check("R4 status repeat", rx, 8'hA6);
      stat_in = 8'h3C;
      sel_on(1); send(8'h05); xfer(8'h00, rx); sel_off();
      check("R3 status byte mode3", rx, 8'h3C);

      // R5: read with ignored upper address bits, then wrap
      sel_on(0); send(8'h03); send(8'hF8); send(8'h10);
      xfer(8'h00, rx); check("R5 read first", rx, mem[16]);
      xfer(8'h00, rx); sel_off(); check("R5 read next", rx, mem[17]);
      sel_on(1); send(8'h03); send(8'hFF); send(8'hFF);
      xfer(8'h00, rx); check("R5 read top", rx, mem[2047]);
      xfer(8'h00, rx); check("R5 read wrap", rx, mem[0]);
      xfer(8'h00, rx); sel_off(); check("R5 read after wrap", rx, mem[1]);

      // R6: read refused while busy
      wip_in = 1'b1;
      sel_on(0); send(8'h03); send(8'h00); send(8'h10); send(8'h00); sel_off();
      check("R6 busy read silent", saw_oe, 0);
      wip_in = 1'b0;

      // R7: write with two data bytes
      sel_on(0); send(8'h02); send(8'hE1); send(8'h23); send(8'h5A); send(8'hC3); sel_off();
      check("R7 byte count", wq_a.size(), 2);
      if (wq_a.size() == 2) begin
         check("R7 first addr", wq_a[0], 11'h123);
         check("R7 first data", wq_d[0], 8'h5A);
         check("R7 second addr", wq_a[1], 11'h124);
         check("R7 second data", wq_d[1], 8'hC3);
      end
      check("R7 commit", n_cm, 1);
      wq_a.delete(); wq_d.delete();

      // R8: extra bits abort
      sel_on(0); send(8'h02); send(8'h00); send(8'h40); send(8'h11);
      for (int i = 0; i < 3; i++) bit_x(1'b1, r);
      sel_off();
      check("R8 write with extra bits", n_cm, 1);
      sel_on(0); send(8'h02); send(8'h00); send(8'h40); sel_off();
      check("R8 write without data", n_cm, 1);
      sel_on(1); send(8'h06); bit_x(1'b0, r); sel_off();
      check("R8 latch on extra bit", n_en, 1);
      wq_a.delete(); wq_d.delete();

      // R9: status write
      sel_on(0); send(8'h01); send(8'h8C); sel_off();
      check("R9 status write count", n_sr, 1);
      check("R9 status write data", last_sr, 8'h8C);
      sel_on(0); send(8'h01); send(8'h0C); bit_x(1'b1, r); sel_off();
      check("R9 status write nine bits", n_sr, 1);

      // R10: unknown opcode parks
      sel_on(0); send(8'hFF); send(8'h06); send(8'h05); send(8'h00); sel_off();
      check("R10 parked no strobe", n_en, 1);
      check("R10 parked no output", saw_oe, 0);

      // R11: pause inside a read byte
      sel_on(0); send(8'h03); send(8'h00); send(8'h20);
      for (int i = 7; i >= 4; i--) begin bit_x(1'b0, r); rx[i] = r; end
      sck = 1'b0; wait_clk(HP);
      hold_n = 1'b0; wait_clk(HP);
      for (int k = 0; k < 3; k++) begin
         sck = 1'b1; mosi = 1'b1; wait_clk(HP);
         sck = 1'b0; wait_clk(HP);
      end
      check("R11 paused enable low", miso_oe, 0);
      hold_n = 1'b1; wait_clk(HP);
      for (int i = 3; i >= 0; i--) begin bit_x(1'b0, r); rx[i] = r; end
      check("R11 byte across pause", rx, mem[32]);
      xfer(8'h00, rx); sel_off();
      check("R11 next byte after pause", rx, mem[33]);

      // R12: deselect while paused after a complete write
      sel_on(0); send(8'h02); send(8'h00); send(8'h50); send(8'h77);
      sck = 1'b0; wait_clk(HP);
      hold_n = 1'b0; wait_clk(HP);
      cs_n = 1'b1; wait_clk(3 * HP);
      hold_n = 1'b1; wait_clk(HP);
      check("R12 commit on paused deselect", n_cm, 2);
      sel_on(0); send(8'h06); sel_off();
      check("R12 engine usable afterwards", n_en, 2);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule